// File: doc/BRIEF.md
# Row-Hit-Aware Multi-Agent Transaction Scheduler

This block sits between several requesting agents (processor ports and an I/O port) and the bank command sequencer of a DRAM controller. Each agent presents an already-decoded request (bank, row, column, read/write flag and a priority level). A round-robin admission arbiter lets at most one agent per cycle place its request into a small per-bank buffer. A bank buffer that is full refuses further requests, and agents that target it are skipped.

Every cycle a selector looks at all pending requests in all bank buffers and offers one to the downstream port under a valid/ready handshake. The block remembers which row is open in each bank. A request that hits the open row of its bank outranks any request that does not, whatever their priorities. A low-priority hit can therefore go ahead of a high-priority conflict in the same bank. To bound the delay of requests passed over this way, each one counts the row-hit dispatches it has had to wait through. Once that count reaches a limit, the request is issued before anything else. The open row of a bank is replaced by the row of each request dispatched to it.

Top module: `txn_sched`

## Requirements
- R1: Admission grants at most one agent per cycle, only an agent whose request is valid and whose target bank buffer is not full. Candidates are served round-robin, starting after the last agent granted. `req_ready[a]` is that grant, and the request is stored at the same clock edge.
- R2: A bank buffer holds `DEPTH` (4) requests. An agent whose target bank buffer holds 4 requests is not granted, while other agents are still served in that cycle.
- R3: Within one bank, requests of equal rank leave in arrival order (the oldest first).
- R4: After reset no bank has an open row, so no request counts as a row hit, row 0 included. When a dispatch handshake completes, the dispatched row becomes the open row of its bank.
- R5: A pending request whose row equals the open row of its bank (a row hit) is chosen before any non-hit request, regardless of priority. This holds in the same bank and across banks.
- R6: Priority is a 2-bit value where a larger value is more urgent. Among row hits the most urgent is chosen. When there are no hits, the most urgent non-hit is chosen.
- R7: Between requests of equal hit status and priority, the lower bank index wins. Within a bank, the older request wins.
- R8: Each dispatch of a row hit adds one to the bypass count of every other pending non-hit request. A request whose count has reached `BYPASS_LIMIT` (8) is dispatched before all others.
- R9: While `dsp_ready` is low, no request is removed. With no new admissions, the offered request stays the same. After reset nothing is offered and no agent is granted.
- R10: The dispatched agent id, column, read/write flag and priority are those of the admitted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_AGENTS | Per-agent request valid |
| req_ready | output | N_AGENTS | Per-agent admission grant (one-hot or zero) |
| req_bank | input | N_AGENTS*BANK_W | Per-agent target bank, agent a in slice a |
| req_row | input | N_AGENTS*ROW_W | Per-agent target row |
| req_col | input | N_AGENTS*COL_W | Per-agent target column |
| req_prio | input | N_AGENTS*PRIO_W | Per-agent priority, larger is more urgent |
| req_we | input | N_AGENTS | Per-agent write flag |
| dsp_valid | output | 1 | A request is offered downstream |
| dsp_ready | input | 1 | Downstream accepts the offered request |
| dsp_agent | output | AG_W | Agent id of the offered request |
| dsp_bank | output | BANK_W | Bank of the offered request |
| dsp_row | output | ROW_W | Row of the offered request |
| dsp_col | output | COL_W | Column of the offered request |
| dsp_prio | output | PRIO_W | Priority of the offered request |
| dsp_we | output | 1 | Write flag of the offered request |

## Verification
The selector is tested with short request sets that each isolate one ranking rule:
- two equal requests in one bank, which separates arrival order from bank order;
- a low-priority hit against a high-priority conflict in the same bank;
- priority-only contests and equal-priority contests across banks;
- several hits mixed with an urgent non-hit, which shows that hit status outranks priority and that priority then orders the hits.

A row-0 request right after reset shows whether an unopened bank is wrongly treated as open. A stream of row hits against one waiting conflict shows that the conflict is released exactly after the eighth bypass. Contention with a full bank, and all three agents asking at once, show the skip rule and that each agent is served once in three cycles.

// File: rtl/txs_pkg.sv
package txs_pkg;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;
    localparam int PRIO_W = 2;
    localparam int AG_W   = 2;
    localparam int BYP_W  = 4;

    typedef struct packed {
        logic [AG_W-1:0]   agent;
        logic [PRIO_W-1:0] prio;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [BYP_W-1:0]  byp;
    } txs_entry_t;
endpackage

// File: rtl/rr_admit.sv
module rr_admit #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] grant_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win;
    logic          any;

    always_comb begin
        int idx;
        grant_o = '0;
        any     = 1'b0;
        win     = ptr_q;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr_q) + i) % N;
            if (!any && cand_i[idx]) begin
                grant_o[idx] = 1'b1;
                any          = 1'b1;
                win          = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (any) begin
            ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end

    // R1: never more than one grant in a cycle
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o))
        else $error("R1: more than one agent granted");

    // R1: a grant only goes to an eligible agent
    a_r1_only_cand: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~cand_i) == '0)
        else $error("R1: grant to an ineligible agent");
endmodule

// File: rtl/bank_queue.sv
module bank_queue
    import txs_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_i,
    input  txs_entry_t             push_ent_i,
    input  logic                   pop_i,
    input  logic [SLOT_W-1:0]      pop_slot_i,
    input  logic [DEPTH-1:0]       bump_i,
    output txs_entry_t [DEPTH-1:0] slot_o,
    output logic [DEPTH-1:0]       vld_o,
    output logic                   full_o
);
    txs_entry_t [DEPTH-1:0] arr_q, arr_n;
    logic [CNT_W-1:0]       cnt_q, cnt_n, wr_idx;

    always_comb begin
        arr_n = arr_q;
        for (int s = 0; s < DEPTH; s++) begin
            if (bump_i[s]) arr_n[s].byp = arr_q[s].byp + 1'b1;
        end
        if (pop_i) begin
            for (int s = 0; s < DEPTH - 1; s++) begin
                if (s >= int'(pop_slot_i)) arr_n[s] = arr_n[s+1];
            end
        end
        wr_idx = cnt_q - CNT_W'(pop_i);
        for (int s = 0; s < DEPTH; s++) begin
            if (push_i && (int'(wr_idx) == s)) arr_n[s] = push_ent_i;
        end
        cnt_n = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            arr_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            arr_q <= arr_n;
        end
    end

    always_comb begin
        for (int s = 0; s < DEPTH; s++) vld_o[s] = (s < int'(cnt_q));
    end
    assign slot_o = arr_q;
    assign full_o = (int'(cnt_q) == DEPTH);

    // R2: no write into a full buffer
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && push_i))
        else $error("R2: push into full bank buffer");

    // R9: removal only of an occupied slot
    a_r9_pop_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> vld_o[pop_slot_i])
        else $error("R9: pop of empty slot");

    // R2: occupancy never exceeds depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH)
        else $error("R2: occupancy above depth");
endmodule

// File: rtl/pick_next.sv
module pick_next
    import txs_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int DEPTH   = 4,
    parameter int LIMIT   = 8,
    localparam int N_ENT  = N_BANKS * DEPTH,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int KEY_W  = 2 + PRIO_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  txs_entry_t [N_ENT-1:0]       ent_i,
    input  logic [N_ENT-1:0]             vld_i,
    input  logic [N_BANKS-1:0]           open_vld_i,
    input  logic [N_BANKS-1:0][ROW_W-1:0] open_row_i,
    output logic                         found_o,
    output logic [IDX_W-1:0]             sel_o,
    output logic [N_ENT-1:0]             hit_o
);
    logic [N_ENT-1:0] starve;
    logic [KEY_W-1:0] best, key;

    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            hit_o[e]  = vld_i[e] && open_vld_i[e / DEPTH]
                        && (ent_i[e].row == open_row_i[e / DEPTH]);
            starve[e] = vld_i[e] && (ent_i[e].byp >= BYP_W'(LIMIT));
        end
    end

    always_comb begin
        found_o = 1'b0;
        sel_o   = '0;
        best    = '0;
        for (int e = 0; e < N_ENT; e++) begin
            key = {starve[e], hit_o[e], ent_i[e].prio};
            if (vld_i[e] && (!found_o || key > best)) begin
                found_o = 1'b1;
                best    = key;
                sel_o   = IDX_W'(e);
            end
        end
    end

    // R5: with no starved request waiting, a hit present means a hit is chosen
    a_r5_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && (|hit_o) && !(|starve)) |-> hit_o[sel_o])
        else $error("R5: non-hit chosen while a hit waits");

    // R8: a starved request always wins the selection
    a_r8_starved_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|starve) |-> starve[sel_o])
        else $error("R8: starved request passed over");
endmodule

// File: rtl/txn_sched.sv
module txn_sched
    import txs_pkg::*;
#(
    parameter int N_AGENTS     = 3,
    parameter int N_BANKS      = 4,
    parameter int DEPTH        = 4,
    parameter int BYPASS_LIMIT = 8,
    localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int N_ENT  = N_BANKS * DEPTH,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_AGENTS-1:0]        req_valid,
    output logic [N_AGENTS-1:0]        req_ready,
    input  logic [N_AGENTS*BANK_W-1:0] req_bank,
    input  logic [N_AGENTS*ROW_W-1:0]  req_row,
    input  logic [N_AGENTS*COL_W-1:0]  req_col,
    input  logic [N_AGENTS*PRIO_W-1:0] req_prio,
    input  logic [N_AGENTS-1:0]        req_we,
    output logic                       dsp_valid,
    input  logic                       dsp_ready,
    output logic [AG_W-1:0]            dsp_agent,
    output logic [BANK_W-1:0]          dsp_bank,
    output logic [ROW_W-1:0]           dsp_row,
    output logic [COL_W-1:0]           dsp_col,
    output logic [PRIO_W-1:0]          dsp_prio,
    output logic                       dsp_we
);
    logic [N_AGENTS-1:0]           cand, grant;
    logic [N_BANKS-1:0]            bq_full, push;
    logic [BANK_W-1:0]             win_bank;
    txs_entry_t                    win_ent;
    txs_entry_t [N_ENT-1:0]        ent;
    logic [N_ENT-1:0]              ent_vld, hit_vec, bump;
    logic                          sel_found, fire;
    logic [IDX_W-1:0]              sel_idx;
    logic [SLOT_W-1:0]             sel_slot;
    txs_entry_t                    sel_ent;
    logic [N_BANKS-1:0]            open_vld;
    logic [N_BANKS-1:0][ROW_W-1:0] open_row;

    // admission
    always_comb begin
        for (int a = 0; a < N_AGENTS; a++) begin
            cand[a] = rst_n && req_valid[a]
                      && !bq_full[req_bank[a*BANK_W +: BANK_W]];
        end
    end

    rr_admit #(.N(N_AGENTS)) u_admit (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (cand),
        .grant_o(grant)
    );
    assign req_ready = grant;

    always_comb begin
        win_bank = '0;
        win_ent  = '0;
        for (int a = 0; a < N_AGENTS; a++) begin
            if (grant[a]) begin
                win_bank      = req_bank[a*BANK_W +: BANK_W];
                win_ent.agent = AG_W'(a);
                win_ent.prio  = req_prio[a*PRIO_W +: PRIO_W];
                win_ent.row   = req_row[a*ROW_W +: ROW_W];
                win_ent.col   = req_col[a*COL_W +: COL_W];
                win_ent.we    = req_we[a];
                win_ent.byp   = '0;
            end
        end
        for (int b = 0; b < N_BANKS; b++) begin
            push[b] = (|grant) && (int'(win_bank) == b);
        end
    end

    // per-bank buffers
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        bank_queue #(.DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_i    (push[b]),
            .push_ent_i(win_ent),
            .pop_i     (fire && (int'(dsp_bank) == b)),
            .pop_slot_i(sel_slot),
            .bump_i    (bump[b*DEPTH +: DEPTH]),
            .slot_o    (ent[b*DEPTH +: DEPTH]),
            .vld_o     (ent_vld[b*DEPTH +: DEPTH]),
            .full_o    (bq_full[b])
        );
    end

    // selection
    pick_next #(.N_BANKS(N_BANKS), .DEPTH(DEPTH), .LIMIT(BYPASS_LIMIT)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_i     (ent),
        .vld_i     (ent_vld),
        .open_vld_i(open_vld),
        .open_row_i(open_row),
        .found_o   (sel_found),
        .sel_o     (sel_idx),
        .hit_o     (hit_vec)
    );

    assign sel_ent  = ent[sel_idx];
    assign sel_slot = SLOT_W'(int'(sel_idx) % DEPTH);
    assign fire     = sel_found && dsp_ready;

    assign dsp_valid = sel_found;
    assign dsp_bank  = BANK_W'(int'(sel_idx) / DEPTH);
    assign dsp_agent = sel_ent.agent;
    assign dsp_row   = sel_ent.row;
    assign dsp_col   = sel_ent.col;
    assign dsp_prio  = sel_ent.prio;
    assign dsp_we    = sel_ent.we;

    // bypass accounting: a dispatched hit passes every waiting non-hit
    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            bump[e] = fire && hit_vec[sel_idx] && ent_vld[e] && !hit_vec[e]
                      && (ent[e].byp < BYP_W'(BYPASS_LIMIT));
        end
    end

    // open-row tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld <= '0;
            open_row <= '0;
        end else if (fire) begin
            open_vld[dsp_bank] <= 1'b1;
            open_row[dsp_bank] <= dsp_row;
        end
    end

    // R4: a completed dispatch opens its row in its bank
    a_r4_open_update: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (open_vld[$past(dsp_bank)] && (open_row[$past(dsp_bank)] == $past(dsp_row))))
        else $error("R4: open row not updated");

    // R9: without a handshake nothing leaves the buffers
    a_r9_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($countones(ent_vld) >= $past($countones(ent_vld))))
        else $error("R9: request lost without handshake");

    // R1: at most one admission per cycle into the buffers
    a_r1_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push))
        else $error("R1: more than one bank written");
endmodule

// File: tb/txn_sched_tb_top.sv
`timescale 1ns/1ps
module txn_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_valid = '0;
    logic [2:0]  req_ready;
    logic [5:0]  req_bank = '0;
    logic [23:0] req_row = '0;
    logic [17:0] req_col = '0;
    logic [5:0]  req_prio = '0;
    logic [2:0]  req_we = '0;
    logic        dsp_valid;
    logic        dsp_ready = 1'b0;
    logic [1:0]  dsp_agent;
    logic [1:0]  dsp_bank;
    logic [7:0]  dsp_row;
    logic [5:0]  dsp_col;
    logic [1:0]  dsp_prio;
    logic        dsp_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txn_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_prio(req_prio), .req_we(req_we),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready),
        .dsp_agent(dsp_agent), .dsp_bank(dsp_bank), .dsp_row(dsp_row),
        .dsp_col(dsp_col), .dsp_prio(dsp_prio), .dsp_we(dsp_we)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(int a, int b, int r, int c, int p, int w);
        @(negedge clk);
        req_bank[a*2 +: 2]  = 2'(b);
        req_row[a*8 +: 8]   = 8'(r);
        req_col[a*6 +: 6]   = 6'(c);
        req_prio[a*2 +: 2]  = 2'(p);
        req_we[a]           = w[0];
        req_valid[a]        = 1'b1;
        #1;
        while (!req_ready[a]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[a] = 1'b0;
    endtask

    // expect the offered request, then accept it
    task automatic take(string tag, int eb, int er, int ea, int ec, int ew);
        @(negedge clk);
        #1;
        chk({tag, " valid"}, int'(dsp_valid), 1);
        chk({tag, " bank"}, int'(dsp_bank), eb);
        chk({tag, " row"}, int'(dsp_row), er);
        chk({tag, " agent"}, int'(dsp_agent), ea);
        if (ec >= 0) chk({tag, " col"}, int'(dsp_col), ec);
        if (ew >= 0) chk({tag, " we"}, int'(dsp_we), ew);
        dsp_ready = 1'b1;
        @(negedge clk);
        dsp_ready = 1'b0;
    endtask

    initial begin
        logic [2:0] g;
        logic [2:0] got;
        repeat (3) @(negedge clk);
        // R9: nothing offered or granted during and right after reset
        chk("R9 reset dsp_valid", int'(dsp_valid), 0);
        chk("R9 reset req_ready", int'(req_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle dsp_valid", int'(dsp_valid), 0);

        // R4: row 0 in an unopened bank is no hit; priority decides
        push(0, 1, 0, 0, 0, 0);
        push(1, 2, 5, 0, 1, 0);
        take("R4 closed bank not hit", 2, 5, 1, -1, -1);
        take("R4 second", 1, 0, 0, -1, -1);

        // R3 / R9 / R10: arrival order within one bank, hold while not ready
        push(0, 0, 5, 1, 1, 0);
        push(1, 0, 6, 2, 1, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R9 hold row", int'(dsp_row), 5);
        end
        take("R3 oldest first", 0, 5, 0, 1, 0);
        @(negedge clk);
        #1;
        chk("R10 prio", int'(dsp_prio), 1);
        take("R10 fields", 0, 6, 1, 2, 1);

        // R5: low-priority hit before high-priority conflict, same bank
        push(2, 0, 9, 3, 3, 0);
        push(0, 0, 6, 4, 0, 0);
        take("R5 hit bypasses", 0, 6, 0, 4, -1);
        take("R5 conflict next", 0, 9, 2, 3, -1);

        // R6: priority among non-hits
        push(0, 1, 1, 0, 1, 0);
        push(1, 2, 2, 0, 2, 0);
        take("R6 urgent non-hit", 2, 2, 1, -1, -1);
        take("R6 next", 1, 1, 0, -1, -1);

        // R7: equal rank, lower bank wins
        push(0, 3, 7, 0, 2, 0);
        push(1, 1, 3, 0, 2, 0);
        take("R7 lower bank", 1, 3, 1, -1, -1);
        take("R7 next", 3, 7, 0, -1, -1);

        // R6 / R5: hits ordered by priority, both ahead of urgent conflict
        push(0, 1, 3, 0, 0, 0);
        push(1, 3, 7, 0, 2, 0);
        push(2, 2, 9, 0, 3, 0);
        take("R6 urgent hit", 3, 7, 1, -1, -1);
        take("R5 low hit", 1, 3, 0, -1, -1);
        take("R5 conflict last", 2, 9, 2, -1, -1);

        // R8: conflict released after eight hit bypasses
        push(2, 0, 1, 0, 3, 0);
        for (int i = 0; i < 3; i++) push(0, 1, 3, 0, 0, 0);
        for (int i = 0; i < 3; i++) push(1, 3, 7, 0, 0, 0);
        for (int i = 0; i < 3; i++) take("R8 hit b1", 1, 3, 0, -1, -1);
        for (int i = 0; i < 3; i++) take("R8 hit b3", 3, 7, 1, -1, -1);
        for (int i = 0; i < 3; i++) push(0, 1, 3, 0, 0, 0);
        take("R8 hit 7", 1, 3, 0, -1, -1);
        take("R8 hit 8", 1, 3, 0, -1, -1);
        take("R8 starved forced", 0, 1, 2, -1, -1);
        take("R8 remaining hit", 1, 3, 0, -1, -1);

        // R4: dispatched row becomes open
        push(0, 2, 4, 0, 3, 0);
        push(1, 0, 1, 0, 0, 0);
        take("R4 new open row hit", 0, 1, 1, -1, -1);
        take("R4 next", 2, 4, 0, -1, -1);

        // R2: full bank skipped, other agent served
        for (int i = 0; i < 4; i++) push(0, 2, 10 + i, 0, 0, 0);
        @(negedge clk);
        req_bank[1:0] = 2'd2; req_row[7:0] = 8'd20; req_valid[0] = 1'b1;
        req_bank[3:2] = 2'd3; req_row[15:8] = 8'd21; req_valid[1] = 1'b1;
        #1;
        chk("R2 full bank refused", int'(req_ready[0]), 0);
        chk("R1 other agent served", int'(req_ready[1]), 1);
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1;
        chk("R2 still refused", int'(req_ready[0]), 0);
        @(negedge clk);
        req_valid[0] = 1'b0;

        // R1: three agents at once, each granted once in three cycles
        req_bank = {2'd0, 2'd0, 2'd0};
        req_valid = 3'b111;
        got = '0;
        for (int c = 0; c < 3; c++) begin
            #1;
            g = req_ready;
            chk("R1 one grant per cycle", $countones(g), 1);
            got = got | g;
            @(negedge clk);
            req_valid = req_valid & ~g;
        end
        chk("R1 all served", int'(got), 7);

        // R9: drain completely
        dsp_ready = 1'b1;
        repeat (20) @(negedge clk);
        dsp_ready = 1'b0;
        #1;
        chk("R9 drained", int'(dsp_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule